// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the interrupt state that lets processors signal one another and that a periodic timer raises on every processor. It serves up to four CPUs. Each CPU has a pending bit for an inter-processor interrupt (IPI) and a separate pending bit for a timer interrupt. Each pending bit drives that CPU's interrupt line directly, so IPIs and timer interrupts reach the core as two distinct levels, apart from any device interrupt.

Software controls the block through one 64-bit control register. A single write carries three independent 4-bit masks, one CPU per bit: an IPI request mask, an IPI clear mask and a timer clear mask. One write can raise, drop and acknowledge interrupts on several CPUs at once. A timer tick input posts a timer interrupt to every present CPU that does not already have one. A request for an IPI that is already pending, and a clear of an IPI that is not pending, are not errors. They leave the state as it is and give a one-cycle indication. Reading the register returns both pending vectors and the number of the CPU that performs the read.

Top module: `irq_ipi_timer_ctl`

## Requirements
- R1: After reset, all IPI and timer pending bits, both interrupt output vectors and both indication pulses are zero.
- R2: A write with bit 12+i of the data set, for a present CPU i, makes `ipi_irq[i]` high from the cycle after the write.
- R3: A write with bit 8+i set, and bit 12+i clear, makes `ipi_irq[i]` low from the cycle after the write.
- R4: Requesting an IPI for a CPU whose IPI is already pending leaves the state unchanged and raises `ipi_dup` for the one cycle after the write.
- R5: A clear of an IPI on a present CPU that has none pending changes nothing and raises `ipi_spur` for the one cycle after the write.
- R6: When one write both clears and requests the IPI of the same CPU, the clear is applied first and the request second. The IPI ends pending, and `ipi_dup` stays low for it.
- R7: A cycle with `tick` high makes `tmr_irq[i]` high in the next cycle for every present CPU i.
- R8: A write with bit 4+i set clears `tmr_irq[i]` from the next cycle. If `tick` is high in the same cycle, the tick wins and the bit stays pending.
- R9: `rd_data` returns, in the same cycle, the IPI pending vector in bits [11:8], the timer pending vector in bits [7:4] and `rd_cpu` in bits [1:0]. All other bits are zero.
- R10: CPUs with an index of `NUM_CPUS` or above are never affected by any field or by `tick`. Their pending bits stay zero.
- R11: `ipi_dup` and `ipi_spur` are high only in the cycle right after a write. They are never high two cycles in a row without a new write.
- R12: One write can request IPIs on some CPUs and clear IPIs on others, and both take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 64 | Write data; request, clear and timer-clear masks |
| tick | input | 1 | Timer tick, one cycle per period |
| rd_cpu | input | 2 | Number of the CPU performing a read |
| rd_data | output | 64 | Read value of the control register |
| ipi_irq | output | 4 | Per-CPU inter-processor interrupt line |
| tmr_irq | output | 4 | Per-CPU timer interrupt line |
| ipi_dup | output | 1 | One-cycle pulse: IPI requested while already pending |
| ipi_spur | output | 1 | One-cycle pulse: IPI cleared while not pending |

## Verification
Every write and tick takes effect through one register stage. The interrupt lines and both pulses therefore change exactly one clock after the cycle in which the stimulus is presented, while `rd_data` follows the registered state combinationally. The driver presents one operation per cycle on the falling edge and queues the expected outputs for that operation. The monitor wakes 1 ns after the next rising edge, pops exactly one item and compares it, so each result is checked in the cycle it is due. Idle operations are queued as well, so the bench also checks that pulses are gone one cycle later.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;
    localparam int MAX_CPUS = 4;
    localparam int REQ_LSB  = 12;
    localparam int CLR_LSB  = 8;
    localparam int TCLR_LSB = 4;
    localparam int RD_IPI_LSB = 8;
    localparam int RD_TMR_LSB = 4;

    typedef logic [MAX_CPUS-1:0] cpu_vec_t;

    typedef struct packed {
        cpu_vec_t pend;
        logic     dup;
        logic     spur;
    } ipi_state_t;
endpackage

// File: rtl/ipi_unit.sv
module ipi_unit
    import irqctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  cpu_vec_t req_i,
    input  cpu_vec_t clr_i,
    output cpu_vec_t pend_o,
    output logic     dup_o,
    output logic     spur_o
);
    ipi_state_t st_d, st_q;
    cpu_vec_t   kept_d;

    always_comb begin
        st_d      = st_q;
        st_d.dup  = 1'b0;
        st_d.spur = 1'b0;
        kept_d    = st_q.pend;
        if (wr_en) begin
            kept_d    = st_q.pend & ~clr_i;
            st_d.spur = |(clr_i & ~st_q.pend);
            st_d.dup  = |(req_i & kept_d);
            st_d.pend = kept_d | req_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign dup_o  = st_q.dup;
    assign spur_o = st_q.spur;

    // R2
    ipi_req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pend_o & $past(req_i)) == $past(req_i)));

    // R3
    ipi_clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pend_o & $past(clr_i & ~req_i)) == '0));

    // R11
    ipi_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pend_o) && !dup_o && !spur_o));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import irqctl_pkg::*;
#(
    parameter cpu_vec_t PRESENT = '1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  cpu_vec_t clr_i,
    output cpu_vec_t pend_o
);
    cpu_vec_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q & ~clr_i;
        if (tick) pend_d = pend_d | PRESENT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R7
    tmr_tick_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((pend_o & PRESENT) == PRESENT));

    // R8
    tmr_clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((pend_o & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_ipi_timer_ctl.sv
module irq_ipi_timer_ctl
    import irqctl_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    input  logic        tick,
    input  logic [1:0]  rd_cpu,
    output logic [63:0] rd_data,
    output logic [3:0]  ipi_irq,
    output logic [3:0]  tmr_irq,
    output logic        ipi_dup,
    output logic        ipi_spur
);
    cpu_vec_t present;
    cpu_vec_t req_m, clr_m, tclr_m;
    cpu_vec_t ipi_pend, tmr_pend;
    logic     unused_bits;

    localparam cpu_vec_t PRESENT_P = cpu_vec_t'((1 << NUM_CPUS) - 1);

    for (genvar i = 0; i < MAX_CPUS; i++) begin : g_lane
        assign present[i] = (i < NUM_CPUS);
    end

    assign req_m  = wr_data[REQ_LSB  +: MAX_CPUS] & present;
    assign clr_m  = wr_data[CLR_LSB  +: MAX_CPUS] & present;
    assign tclr_m = wr_en ? (wr_data[TCLR_LSB +: MAX_CPUS] & present) : '0;
    assign unused_bits = ^{wr_data[63:16], wr_data[3:0]};

    ipi_unit u_ipi (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .req_i  (req_m),
        .clr_i  (clr_m),
        .pend_o (ipi_pend),
        .dup_o  (ipi_dup),
        .spur_o (ipi_spur)
    );

    tmr_unit #(.PRESENT(PRESENT_P)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr_i  (tclr_m),
        .pend_o (tmr_pend)
    );

    always_comb begin
        rd_data = '0;
        rd_data[RD_IPI_LSB +: MAX_CPUS] = ipi_pend;
        rd_data[RD_TMR_LSB +: MAX_CPUS] = tmr_pend;
        rd_data[1:0] = rd_cpu;
    end

    assign ipi_irq = ipi_pend;
    assign tmr_irq = tmr_pend;

    // R10
    absent_cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq | tmr_irq) & ~PRESENT_P) == '0);
endmodule

// File: tb/irq_ipi_timer_ctl_test.sv
module irq_ipi_timer_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [1:0]  rd_cpu = '0;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq, tmr_irq;
    logic        ipi_dup, ipi_spur;

    always #2 clk = ~clk;

    irq_ipi_timer_ctl #(.NUM_CPUS(3)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_cpu(rd_cpu), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .ipi_dup(ipi_dup), .ipi_spur(ipi_spur)
    );

    typedef struct {
        logic [3:0]  ipi;
        logic [3:0]  tmr;
        logic        dup;
        logic        spur;
        logic [63:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic [3:0] m_ipi = '0;
    logic [3:0] m_tmr = '0;
    localparam logic [3:0] MASK = 4'b0111;

    task automatic op(input bit w, input logic [15:0] d, input bit t,
                      input logic [1:0] cpu, input string tag);
        exp_t e;
        logic [3:0] req, clr, tclr, kept;
        @(negedge clk);
        wr_en = w; wr_data = {48'b0, d}; tick = t; rd_cpu = cpu;
        req  = w ? d[15:12] & MASK : 4'b0;
        clr  = w ? d[11:8]  & MASK : 4'b0;
        tclr = w ? d[7:4]   & MASK : 4'b0;
        kept = m_ipi & ~clr;
        e.spur = |(clr & ~m_ipi);
        e.dup  = |(req & kept);
        m_ipi  = kept | req;
        m_tmr  = (m_tmr & ~tclr) | (t ? MASK : 4'b0);
        e.ipi = m_ipi; e.tmr = m_tmr;
        e.rd  = {52'b0, m_ipi, m_tmr, 2'b00, cpu};
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (ipi_irq !== e.ipi || tmr_irq !== e.tmr || ipi_dup !== e.dup ||
                ipi_spur !== e.spur || rd_data !== e.rd) begin
                fails++;
                $display("FAIL %s: act ipi=%h tmr=%h dup=%b spur=%b rd=%h exp ipi=%h tmr=%h dup=%b spur=%b rd=%h",
                         e.tag, ipi_irq, tmr_irq, ipi_dup, ipi_spur, rd_data,
                         e.ipi, e.tmr, e.dup, e.spur, e.rd);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset, before any stimulus
        checks++;
        if (ipi_irq !== 4'h0 || tmr_irq !== 4'h0 || ipi_dup !== 1'b0 ||
            ipi_spur !== 1'b0 || rd_data !== 64'h0) begin
            fails++;
            $display("FAIL R1: act ipi=%h tmr=%h rd=%h exp all zero", ipi_irq, tmr_irq, rd_data);
        end
        rst_n = 1'b1;
        op(0, 16'h0000, 0, 2'd0, "R1 idle after reset");
        op(1, 16'h1000, 0, 2'd1, "R2 request cpu0");
        op(1, 16'h1000, 0, 2'd2, "R4 duplicate request cpu0");
        op(0, 16'h0000, 0, 2'd3, "R11 pulse dropped");
        op(1, 16'h0200, 0, 2'd0, "R5 spurious clear cpu1");
        op(0, 16'h0000, 0, 2'd0, "R11 spur pulse dropped");
        op(1, 16'h6100, 0, 2'd1, "R12 request cpu1,2 clear cpu0");
        op(1, 16'h2200, 0, 2'd2, "R6 clear+request cpu1");
        op(1, 16'h8800, 0, 2'd3, "R10 absent cpu3 fields ignored");
        op(0, 16'h0000, 1, 2'd0, "R7 tick posts timers");
        op(1, 16'h0010, 0, 2'd1, "R8 timer clear cpu0");
        op(1, 16'h0010, 1, 2'd2, "R8 timer clear with tick");
        op(1, 16'h00A0, 0, 2'd3, "R10 timer clear cpu1 and absent cpu3");
        op(0, 16'h0000, 1, 2'd1, "R7 tick with cpu0 pending");
        op(1, 16'h0F00, 0, 2'd0, "R3 clear all ipis");
        op(0, 16'h0000, 0, 2'd2, "R9 readback idle");
        op(1, 16'h00F0, 0, 2'd3, "R8 clear all timers");
        @(negedge clk);
        wr_en = 0; tick = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: act running exp finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule